// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block turns one 8-bit up-counter into a rectangular waveform generator. Two compare values are supplied: a period value and a width value. The counter advances once for each cycle in which the prescaled count-enable input `tick` is high. An output flip-flop flips when the counter reaches the width value and flips back when it reaches the period value. The result is a repeating pulse whose period and duty are set independently. The flip-flop's starting level is loaded while the timer is stopped. The part of each period spent at that level is the programmed pulse, so loading a low starting level gives an active-low pulse.

The period value can be double-buffered. When buffering is on and the timer is running, a new period is held in a staging register. It moves into the active compare register only at the end of the current period, so no period is ever cut short or stretched by a write. The usual sequence is: stop the timer, which clears the counter; load both compare values and the flip-flop level; then start counting.

Top module: `ppg_timer`

## Requirements
- R1: After reset `pulse_out` is 0 and the counter is 0.
- R2: With a valid width, the output pattern repeats every P ticks, where P is the active period value and a period value of 0 stands for 256 ticks.
- R3: After start, in each period the output sits at the loaded starting level for the first W ticks (W = width value) and at the opposite level for the remaining P−W ticks. Put as a formula, after n ticks the output equals the starting level when (n mod P) < W and its inverse otherwise.
- R4: With `inv_en` low, `pulse_out` never changes except through a force write.
- R5: A width value of 0, or one at or above a nonzero period value, leaves `pulse_out` at its loaded level (no toggles at all).
- R6: While `run` is low the counter is held at 0. After `run` goes high, the first tick begins a fresh period.
- R7: `pulse_out` changes only on clock edges where `tick` is high or `ff_wr` is high.
- R8: With `dbuf_en` high while running, a `period_wr` only stages the new value. The running period completes at its old length, and the new length applies from the next period on.
- R9: With `dbuf_en` low, or while stopped, a `period_wr` updates the active period at once. The counter then matches against the new value from the following tick.
- R10: `ff_wr` loads `ff_val` into the output flip-flop on the next edge, and this takes priority over a toggle on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable, one cycle per count |
| run | input | 1 | 1 = count, 0 = stop and clear counter |
| inv_en | input | 1 | Enables toggling of the output flip-flop on matches |
| dbuf_en | input | 1 | Enables double buffering of the period value |
| width_val | input | 8 | Width compare value |
| period_val | input | 8 | Period value written by `period_wr` |
| period_wr | input | 1 | Write strobe for the period value |
| ff_wr | input | 1 | Force-load strobe for the output flip-flop |
| ff_val | input | 1 | Level loaded by `ff_wr` |
| pulse_out | output | 1 | Pulse output |

## Verification
The main function is swept over every period from 2 to 10 combined with every width from 0 to P+1, for both starting levels. This separates correct toggle points from off-by-one match errors, and shows the zero and too-large widths holding the output flat. Each of these configurations also starts from a stop, so a counter that is not cleared by stopping shows up as a shifted phase. A 256-tick period checks the wrap case. Sparse ticks show that the output advances per tick rather than per clock. Writing a period mid-run, once buffered and once unbuffered, tells deferred from immediate take-over. A force write on the very tick of a width match shows that the force wins over the toggle.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    typedef enum logic [1:0] {
        FF_HOLD   = 2'd0,
        FF_TOGGLE = 2'd1,
        FF_FORCE  = 2'd2
    } ppg_ff_act_e;
endpackage

// File: rtl/ppg_counter.sv
module ppg_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] period_act,
    input  logic [CW-1:0] width_val,
    output logic          period_hit,
    output logic          width_hit,
    output logic          width_ok
);
    localparam logic [CW-1:0] ZERO = '0;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        st_d       = st_q;
        cnt_inc    = st_q.cnt + 1'b1;
        period_hit = run && tick && (cnt_inc == period_act);
        width_hit  = run && tick && (cnt_inc == width_val);
        width_ok   = (width_val != ZERO) &&
                     ((period_act == ZERO) || (width_val < period_act));
        if (!run) begin
            st_d.cnt = ZERO;
        end else if (tick) begin
            st_d.cnt = period_hit ? ZERO : cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.cnt == ZERO); // R6
    AST_WRAP_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        period_hit |=> st_q.cnt == ZERO); // R2
endmodule

// File: rtl/ppg_period_reg.sv
module ppg_period_reg #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          dbuf_en,
    input  logic          period_wr,
    input  logic [CW-1:0] period_val,
    input  logic          period_hit,
    output logic [CW-1:0] period_act
);
    typedef struct packed {
        logic [CW-1:0] stage;
        logic [CW-1:0] act;
    } per_state_t;

    per_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (period_wr) begin
            st_d.stage = period_val;
        end
        if (period_wr && (!dbuf_en || !run)) begin
            st_d.act = period_val;
        end else if (dbuf_en && period_hit) begin
            st_d.act = st_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign period_act = st_q.act;

    AST_DBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dbuf_en && !period_hit) |=> $stable(st_q.act)); // R8
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (period_wr && !dbuf_en) |=> st_q.act == $past(period_val)); // R9
endmodule

// File: rtl/ppg_out_ff.sv
module ppg_out_ff
    import ppg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ff_wr,
    input  logic ff_val,
    input  logic toggle,
    output logic level
);
    typedef struct packed {
        logic lvl;
    } ff_state_t;

    ff_state_t   st_d, st_q;
    ppg_ff_act_e act;

    always_comb begin
        st_d = st_q;
        if (ff_wr)       act = FF_FORCE;
        else if (toggle) act = FF_TOGGLE;
        else             act = FF_HOLD;
        case (act)
            FF_FORCE:  st_d.lvl = ff_val;
            FF_TOGGLE: st_d.lvl = !st_q.lvl;
            default:   st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;

    AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ff_wr |=> st_q.lvl == $past(ff_val)); // R10
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          inv_en,
    input  logic          dbuf_en,
    input  logic [CW-1:0] width_val,
    input  logic [CW-1:0] period_val,
    input  logic          period_wr,
    input  logic          ff_wr,
    input  logic          ff_val,
    output logic          pulse_out
);
    logic [CW-1:0] period_act;
    logic          period_hit;
    logic          width_hit;
    logic          width_ok;
    logic          toggle;

    ppg_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick),
        .period_act (period_act),
        .width_val  (width_val),
        .period_hit (period_hit),
        .width_hit  (width_hit),
        .width_ok   (width_ok)
    );

    ppg_period_reg #(.CW(CW)) u_per (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .dbuf_en    (dbuf_en),
        .period_wr  (period_wr),
        .period_val (period_val),
        .period_hit (period_hit),
        .period_act (period_act)
    );

    always_comb begin
        toggle = inv_en && width_ok && (width_hit || period_hit);
    end

    ppg_out_ff u_ff (
        .clk    (clk),
        .rst_n  (rst_n),
        .ff_wr  (ff_wr),
        .ff_val (ff_val),
        .toggle (toggle),
        .level  (pulse_out)
    );

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ff_wr) |=> $stable(pulse_out)); // R7
    AST_NO_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_en && !ff_wr) |=> $stable(pulse_out)); // R4
    AST_BAD_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!width_ok && !ff_wr) |=> $stable(pulse_out)); // R5
endmodule

// File: tb/ppg_timer_test.sv
module ppg_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       run = 1'b0;
    logic       inv_en = 1'b0;
    logic       dbuf_en = 1'b0;
    logic [7:0] width_val = '0;
    logic [7:0] period_val = '0;
    logic       period_wr = 1'b0;
    logic       ff_wr = 1'b0;
    logic       ff_val = 1'b0;
    logic       pulse_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppg_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .inv_en(inv_en),
        .dbuf_en(dbuf_en), .width_val(width_val), .period_val(period_val),
        .period_wr(period_wr), .ff_wr(ff_wr), .ff_val(ff_val),
        .pulse_out(pulse_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: pulse_out=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic expect_lvl(int n, int p, int w, logic lvl, logic inv);
        int pp;
        pp = (p == 0) ? 256 : p;
        if (!inv || w == 0 || w >= pp) return lvl;
        return ((n % pp) < w) ? lvl : ~lvl;
    endfunction

    // Stop, load config, then start; returns at the negedge right after run rises.
    task automatic setup(input int p, input int w, input logic lvl,
                         input logic inv, input logic dbuf);
        @(negedge clk);
        run = 1'b0; tick = 1'b1;
        period_val = p[7:0]; period_wr = 1'b1;
        width_val = w[7:0]; ff_wr = 1'b1; ff_val = lvl;
        inv_en = inv; dbuf_en = dbuf;
        @(negedge clk);
        period_wr = 1'b0; ff_wr = 1'b0; run = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pulse_out, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(pulse_out, 1'b0, "R1");

        // R2 R3 R5 R6 R9: sweep of period and width for both levels
        for (int p = 2; p <= 10; p++) begin
            for (int w = 0; w <= p + 1; w++) begin
                for (int l = 0; l < 2; l++) begin
                    setup(p, w, l[0], 1'b1, l[0]);
                    check(pulse_out, l[0], "R6");
                    for (int n = 1; n <= 2 * p + 2; n++) begin
                        @(posedge clk); @(negedge clk);
                        check(pulse_out, expect_lvl(n, p, w, l[0], 1'b1),
                              (w == 0 || w >= p) ? "R5" : "R3");
                    end
                end
            end
        end

        // R2: period value 0 means 256 ticks
        setup(0, 128, 1'b0, 1'b1, 1'b0);
        for (int n = 1; n <= 300; n++) begin
            @(posedge clk); @(negedge clk);
            check(pulse_out, expect_lvl(n, 0, 128, 1'b0, 1'b1), "R2");
        end

        // R4: toggling disabled
        setup(5, 2, 1'b1, 1'b0, 1'b0);
        for (int n = 1; n <= 12; n++) begin
            @(posedge clk); @(negedge clk);
            check(pulse_out, 1'b1, "R4");
        end

        // R7: sparse ticks, one every third cycle
        begin
            int n;
            n = 0;
            setup(4, 1, 1'b0, 1'b1, 1'b0);
            for (int c = 0; c < 40; c++) begin
                tick = (c % 3 == 0);
                @(posedge clk);
                if (tick) n++;
                @(negedge clk);
                check(pulse_out, expect_lvl(n, 4, 1, 1'b0, 1'b1), "R7");
            end
            tick = 1'b1;
        end

        // R8: buffered period write mid-run, old period 8 completes, then 5
        setup(8, 2, 1'b0, 1'b1, 1'b1);
        for (int n = 1; n <= 25; n++) begin
            if (n == 4) begin period_val = 8'd5; period_wr = 1'b1; end
            @(posedge clk); @(negedge clk);
            period_wr = 1'b0;
            check(pulse_out, (n < 8) ? expect_lvl(n, 8, 2, 1'b0, 1'b1)
                                     : expect_lvl(n - 8, 5, 2, 1'b0, 1'b1), "R8");
        end

        // R9: unbuffered period write mid-run, counter matches 5 at tick 5
        setup(8, 2, 1'b0, 1'b1, 1'b0);
        for (int n = 1; n <= 20; n++) begin
            if (n == 4) begin period_val = 8'd5; period_wr = 1'b1; end
            @(posedge clk); @(negedge clk);
            period_wr = 1'b0;
            check(pulse_out, (n < 5) ? expect_lvl(n, 8, 2, 1'b0, 1'b1)
                                     : expect_lvl(n - 5, 5, 2, 1'b0, 1'b1), "R9");
        end

        // R10: force on the width-match tick beats the toggle
        setup(6, 3, 1'b1, 1'b1, 1'b0);
        for (int n = 1; n <= 3; n++) begin
            if (n == 3) begin ff_wr = 1'b1; ff_val = 1'b1; end
            @(posedge clk); @(negedge clk);
            ff_wr = 1'b0;
            check(pulse_out, 1'b1, "R10");
        end
        // R10: force while stopped sets the level
        run = 1'b0; ff_wr = 1'b1; ff_val = 1'b0;
        @(posedge clk); @(negedge clk);
        ff_wr = 1'b0;
        check(pulse_out, 1'b0, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule